// File: doc/BRIEF.md
# Execute-Stage Prefix Decoder with Hidden Operand Register

This block sits in the execute stage of a small 8-bit single-issue core. Every clock it takes the opcode now executing and the opcode fetched behind it. It sorts the opcode into an instruction class and picks the source operand from the four visible registers. It raises the destination write enable and the memory, input and output strobes, and chooses what goes onto the external data address lines.

Three prefix opcodes (constant, memory-read and input) put their result in a hidden register K. For exactly one instruction after a prefix, the operand comes from K, and the source field of that instruction is ignored. A constant prefix holds only six value bits. The two missing high bits come from the low two bits of the opcode behind it. K is loaded on every clock edge: from the constant, the memory data, the input bus or the datapath result, depending on the class. A zero flag is a pure comparison on K. An instruction that makes no data-memory access puts a free-running refresh counter on the address lines, and that counter then advances.

The ALU is outside the block. The datapath result enters on `alu_res`. The block steps once per clock with no stall and no handshake, so no stream interface applies.

Top module: `pfxd_top`

## Requirements
- R1: While `rst_n` is low, K, the prefix-active flag, the after-constant flag and the refresh counter are all zero. Straight after reset the zero flag is 1 and `ext_addr` shows counter value 0.
- R2: When no prefix is active, `src_val` follows opcode bits 1..0: 00 selects `rf_a`, 01 `rf_x`, 10 `rf_y`, 11 `rf_u`. While a prefix is active, `src_val` equals K.
- R3: An opcode 00nnnnnn that does not directly follow a constant prefix is a constant prefix. At the clock edge K takes bits 7..6 from `nx_op[1:0]` and bits 5..0 from `ex_op[5:0]`.
- R4: An opcode 00xxxxxx directly after a constant prefix is a branch. It loads no constant, writes no register and leaves no prefix active.
- R5: Memory prefix 011111rr raises `mem_re`, drives the operand onto `ext_addr` and loads K from `mem_rdata`.
- R6: Input prefix 01110xxx (0x70 to 0x77) raises `in_stb` and loads K from `in_data`.
- R7: Output 01100xxx (0x60 to 0x67) raises `out_stb` only: no register write and no memory strobe. At most one of `mem_we`, `mem_re`, `in_stb` and `out_stb` is high in any cycle.
- R8: Store 011011rr raises `mem_we` with the operand on `ext_addr` and writes no register.
- R9: Arithmetic 100aaarr writes destination 0 (A). Compare 101aaarr writes nothing. 11ddffrr writes destination dd (bits 5..4). When ff=11, that opcode also raises `mem_re` with the operand on `ext_addr` and loads K from `mem_rdata`.
- R10: Any opcode other than store, memory prefix or 11dd11rr drives the refresh counter onto `ext_addr`, and the counter then increments modulo 2^RW. Memory opcodes hold the counter.
- R11: Every opcode that is neither a constant prefix, memory prefix, input prefix nor 11dd11rr loads K from `alu_res` at the clock edge.
- R12: `zero_flag` is 1 exactly when K is zero.
- R13: The prefix-active flag is set for the one cycle after a prefix and clears after any non-prefix instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_op | input | 8 | Opcode in the execute stage |
| nx_op | input | 8 | Opcode fetched behind it |
| rf_a | input | W | Register A (accumulator) value |
| rf_x | input | W | Register X value |
| rf_y | input | W | Register Y value |
| rf_u | input | W | Register U value |
| mem_rdata | input | W | Data memory read value |
| in_data | input | W | External input bus value |
| alu_res | input | W | Datapath result of the current instruction |
| src_val | output | W | Selected source operand |
| dst_sel | output | 2 | Destination register number |
| dst_we | output | 1 | Destination write enable |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| in_stb | output | 1 | Input strobe |
| out_stb | output | 1 | Output strobe |
| ext_addr | output | W | External data address: operand or refresh count |
| k_q | output | W | Hidden register K |
| zero_flag | output | 1 | K equals zero |
| pfx_act | output | 1 | A prefix is active for the current instruction |

## Verification
The bench uses the defaults W = 8 and RW = 8. At these widths the constant split across two opcodes fills K exactly, and the refresh counter can be walked to 255 and across its wrap to 0 in a few hundred cycles. A store placed right after the wrap then shows that memory access holds the count. Distinct register values (0x11, 0x22, 0x33, 0x44) let each operand check tell a register-file pick from a K override.

// File: rtl/pfxd_pkg.sv
package pfxd_pkg;

  typedef enum logic [3:0] {
    IC_CONST, IC_BRANCH, IC_RET, IC_OUT, IC_STA, IC_INP,
    IC_MEM, IC_ALU, IC_CMP, IC_UNARY, IC_LOADM, IC_NOP
  } icls_t;

  typedef enum logic [1:0] {KS_ALU, KS_CONST, KS_MEM, KS_IN} ksrc_t;

  typedef struct packed {
    icls_t      cls;
    ksrc_t      ksrc;
    logic       is_prefix;
    logic       is_const;
    logic       dst_we;
    logic [1:0] dst;
    logic       mem_acc;
    logic       mem_we;
    logic       mem_re;
    logic       out_stb;
    logic       in_stb;
  } ctl_t;

  localparam int OPW = 8;

  // Priority order matters: the 11dd11rr row must be tested before the wider 11 row.
  function automatic icls_t classify(input logic [OPW-1:0] op, input logic after_const);
    icls_t c;
    casez (op)
      8'b00??????: c = after_const ? IC_BRANCH : IC_CONST;
      8'b010?????: c = IC_RET;
      8'b01100???: c = IC_OUT;
      8'b011011??: c = IC_STA;
      8'b01110???: c = IC_INP;
      8'b011111??: c = IC_MEM;
      8'b100?????: c = IC_ALU;
      8'b101?????: c = IC_CMP;
      8'b11??11??: c = IC_LOADM;
      8'b11??????: c = IC_UNARY;
      default:     c = IC_NOP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pfxd_classify.sv
module pfxd_classify
  import pfxd_pkg::*;
(
  input  logic [OPW-1:0] ex_op,
  input  logic           after_const,
  output ctl_t           ctl
);

  icls_t cls;

  always_comb begin
    cls      = classify(ex_op, after_const);
    ctl      = '0;
    ctl.cls  = cls;
    ctl.ksrc = KS_ALU;
    unique case (cls)
      IC_CONST: begin
        ctl.ksrc      = KS_CONST;
        ctl.is_prefix = 1'b1;
        ctl.is_const  = 1'b1;
      end
      IC_MEM: begin
        ctl.ksrc      = KS_MEM;
        ctl.is_prefix = 1'b1;
        ctl.mem_acc   = 1'b1;
        ctl.mem_re    = 1'b1;
      end
      IC_INP: begin
        ctl.ksrc      = KS_IN;
        ctl.is_prefix = 1'b1;
        ctl.in_stb    = 1'b1;
      end
      IC_OUT: ctl.out_stb = 1'b1;
      IC_STA: begin
        ctl.mem_acc = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      IC_ALU: begin
        ctl.dst_we = 1'b1;
        ctl.dst    = 2'd0;
      end
      IC_LOADM: begin
        ctl.ksrc    = KS_MEM;
        ctl.dst_we  = 1'b1;
        ctl.dst     = ex_op[5:4];
        ctl.mem_acc = 1'b1;
        ctl.mem_re  = 1'b1;
      end
      IC_UNARY: begin
        ctl.dst_we = 1'b1;
        ctl.dst    = ex_op[5:4];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pfxd_opsel.sv
module pfxd_opsel #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] u,
  input  logic [1:0]   sel,
  input  logic         use_k,
  input  logic [W-1:0] k,
  output logic [W-1:0] src
);

  logic [W-1:0] bank [4];

  assign bank[0] = a;
  assign bank[1] = x;
  assign bank[2] = y;
  assign bank[3] = u;

  assign src = use_k ? k : bank[sel];

endmodule

// File: rtl/pfxd_khold.sv
module pfxd_khold
  import pfxd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ksrc_t        ksrc,
  input  logic         is_prefix,
  input  logic         is_const,
  input  logic [W-1:0] const_val,
  input  logic [W-1:0] mem_d,
  input  logic [W-1:0] in_d,
  input  logic [W-1:0] alu_d,
  output logic [W-1:0] k_q,
  output logic         pfx_q,
  output logic         cst_q
);

  logic [W-1:0] k_d;
  logic         past_ok;

  always_comb begin
    unique case (ksrc)
      KS_CONST: k_d = const_val;
      KS_MEM:   k_d = mem_d;
      KS_IN:    k_d = in_d;
      default:  k_d = alu_d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q     <= '0;
      pfx_q   <= 1'b0;
      cst_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      k_q     <= k_d;
      pfx_q   <= is_prefix;
      cst_q   <= is_const;
      past_ok <= 1'b1;
    end
  end

  // R13: the prefix flag lives for one instruction only
  assert_pfx_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(pfx_q) && !$past(is_prefix) |-> !pfx_q);

  // R1/R3: a constant flag never stands without the prefix flag
  assert_const_implies_pfx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cst_q |-> pfx_q);

endmodule

// File: rtl/pfxd_refresh.sv
module pfxd_refresh #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  output logic [RW-1:0] cnt
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (!hold) cnt <= cnt + 1'b1;
    end
  end

  assert_refresh_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(hold) |-> cnt == RW'($past(cnt) + 1'b1));

  assert_refresh_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(hold) |-> $stable(cnt));

endmodule

// File: rtl/pfxd_top.sv
module pfxd_top
  import pfxd_pkg::*;
#(
  parameter int W  = 8,
  parameter int RW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   ex_op,
  input  logic [7:0]   nx_op,
  input  logic [W-1:0] rf_a,
  input  logic [W-1:0] rf_x,
  input  logic [W-1:0] rf_y,
  input  logic [W-1:0] rf_u,
  input  logic [W-1:0] mem_rdata,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] alu_res,
  output logic [W-1:0] src_val,
  output logic [1:0]   dst_sel,
  output logic         dst_we,
  output logic         mem_we,
  output logic         mem_re,
  output logic         in_stb,
  output logic         out_stb,
  output logic [W-1:0] ext_addr,
  output logic [W-1:0] k_q,
  output logic         zero_flag,
  output logic         pfx_act
);

  localparam int CBITS = 6;

  ctl_t          ctl;
  logic          cst_q;
  logic [RW-1:0] rfc;
  logic [W-1:0]  const_val;
  logic          past_ok;

  assign const_val = W'({nx_op[1:0], ex_op[CBITS-1:0]});

  pfxd_classify u_cls (
    .ex_op       (ex_op),
    .after_const (cst_q),
    .ctl         (ctl)
  );

  pfxd_opsel #(.W(W)) u_sel (
    .a     (rf_a),
    .x     (rf_x),
    .y     (rf_y),
    .u     (rf_u),
    .sel   (ex_op[1:0]),
    .use_k (pfx_act),
    .k     (k_q),
    .src   (src_val)
  );

  pfxd_khold #(.W(W)) u_k (
    .clk       (clk),
    .rst_n     (rst_n),
    .ksrc      (ctl.ksrc),
    .is_prefix (ctl.is_prefix),
    .is_const  (ctl.is_const),
    .const_val (const_val),
    .mem_d     (mem_rdata),
    .in_d      (in_data),
    .alu_d     (alu_res),
    .k_q       (k_q),
    .pfx_q     (pfx_act),
    .cst_q     (cst_q)
  );

  pfxd_refresh #(.RW(RW)) u_rfc (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (ctl.mem_acc),
    .cnt   (rfc)
  );

  assign dst_sel   = ctl.dst;
  assign dst_we    = ctl.dst_we;
  assign mem_we    = ctl.mem_we;
  assign mem_re    = ctl.mem_re;
  assign in_stb    = ctl.in_stb;
  assign out_stb   = ctl.out_stb;
  assign ext_addr  = ctl.mem_acc ? src_val : W'(rfc);
  assign zero_flag = (k_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_k_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ctl.is_const) |-> k_q == W'({$past(nx_op[1:0]), $past(ex_op[CBITS-1:0])}));

  assert_src_from_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_act |-> src_val == k_q);

  assert_sta_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ext_addr == src_val && !dst_we);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re, in_stb, out_stb}));

  assert_branch_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(ctl.is_const) && ex_op[7:6] == 2'b00 |-> !dst_we);

endmodule

// File: tb/pfxd_top_tb_top.sv
module pfxd_top_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   ex_op = 8'h00;
  logic [7:0]   nx_op = 8'h00;
  logic [W-1:0] rf_a = 8'h11, rf_x = 8'h22, rf_y = 8'h33, rf_u = 8'h44;
  logic [W-1:0] mem_rdata = 8'hA5, in_data = 8'h5C, alu_res = 8'h77;
  logic [W-1:0] src_val, ext_addr, k_q;
  logic [1:0]   dst_sel;
  logic         dst_we, mem_we, mem_re, in_stb, out_stb, zero_flag, pfx_act;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  logic [7:0] exp_rfc;

  always #5 clk = ~clk;

  pfxd_top #(.W(W), .RW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ex_op(ex_op), .nx_op(nx_op),
    .rf_a(rf_a), .rf_x(rf_x), .rf_y(rf_y), .rf_u(rf_u),
    .mem_rdata(mem_rdata), .in_data(in_data), .alu_res(alu_res),
    .src_val(src_val), .dst_sel(dst_sel), .dst_we(dst_we),
    .mem_we(mem_we), .mem_re(mem_re), .in_stb(in_stb), .out_stb(out_stb),
    .ext_addr(ext_addr), .k_q(k_q), .zero_flag(zero_flag), .pfx_act(pfx_act)
  );

  function automatic bit is_mem_op(input logic [7:0] op);
    return (op[7:2] == 6'b011011) || (op[7:2] == 6'b011111) ||
           (op[7:6] == 2'b11 && op[3:2] == 2'b11);
  endfunction

  // refresh model taken from R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_rfc <= 8'h00;
    else if (!is_mem_op(ex_op)) exp_rfc <= exp_rfc + 8'h01;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] ex, input logic [7:0] nx);
    @(negedge clk);
    ex_op = ex;
    nx_op = nx;
    #2;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    ex_op = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ex_op = 8'h68;
    #2;
    chk("R1 k after reset", 32'(k_q), 32'h0);
    chk("R1 prefix after reset", 32'(pfx_act), 32'h0);
    chk("R1 refresh addr after reset", 32'(ext_addr), 32'h0);
    chk("R12 zero flag on K=0", 32'(zero_flag), 32'h1);
  endtask

  task automatic t_srcsel;
    logic [W-1:0] regs [4];
    regs[0] = rf_a; regs[1] = rf_x; regs[2] = rf_y; regs[3] = rf_u;
    for (int i = 0; i < 4; i++) begin
      apply(8'hC8 | 8'(i), 8'h00);
      chk("R2 source select", 32'(src_val), 32'(regs[i]));
      chk("R9 load writes dest 0", 32'({dst_we, dst_sel}), 32'h4);
    end
    apply(8'hD9, 8'h00);
    chk("R9 dest field bits 5..4", 32'({dst_we, dst_sel}), 32'h5);
  endtask

  task automatic t_const;
    apply(8'h2A, 8'h8E);
    apply(8'h8E, 8'h00);
    chk("R3 K from split constant", 32'(k_q), 32'hAA);
    chk("R13 prefix active", 32'(pfx_act), 32'h1);
    chk("R2 operand overridden by K", 32'(src_val), 32'hAA);
    chk("R9 arith writes A", 32'({dst_we, dst_sel}), 32'h4);
    apply(8'h8E, 8'h00);
    chk("R13 prefix cleared", 32'(pfx_act), 32'h0);
    chk("R2 operand back to Y", 32'(src_val), 32'h33);
    chk("R11 K from alu_res", 32'(k_q), 32'h77);
  endtask

  task automatic t_branch;
    apply(8'h15, 8'h0B);
    apply(8'h0B, 8'hC8);
    chk("R3 K before branch", 32'(k_q), 32'hD5);
    chk("R4 branch writes no register", 32'(dst_we), 32'h0);
    apply(8'hC8, 8'h00);
    chk("R4 branch leaves no prefix", 32'(pfx_act), 32'h0);
    chk("R4 branch loads no constant", 32'(k_q), 32'h77);
    chk("R2 operand A after branch", 32'(src_val), 32'h11);
  endtask

  task automatic t_mem;
    logic [7:0] r0;
    apply(8'h7E, 8'h00);
    chk("R5 mem prefix read strobe", 32'(mem_re), 32'h1);
    chk("R5 mem prefix address", 32'(ext_addr), 32'h33);
    r0 = exp_rfc;
    apply(8'hCB, 8'h00);
    chk("R5 K from memory", 32'(k_q), 32'hA5);
    chk("R5 operand bits ignored", 32'(src_val), 32'hA5);
    chk("R10 memory prefix held counter", 32'(ext_addr), 32'(r0));
  endtask

  task automatic t_inp;
    apply(8'h73, 8'h00);
    chk("R6 input strobe", 32'({in_stb, mem_re, out_stb}), 32'h4);
    apply(8'h81, 8'h00);
    chk("R6 K from input bus", 32'(k_q), 32'h5C);
    chk("R6 operand from K", 32'(src_val), 32'h5C);
    chk("R6 no input strobe on arith", 32'(in_stb), 32'h0);
  endtask

  task automatic t_out_sta;
    apply(8'h65, 8'h00);
    chk("R7 output strobe only", 32'({out_stb, in_stb, mem_we, mem_re, dst_we}), 32'h10);
    chk("R10 refresh addr on output", 32'(ext_addr), 32'(exp_rfc));
    apply(8'h6D, 8'h00);
    chk("R8 store strobe", 32'({mem_we, dst_we, mem_re}), 32'h4);
    chk("R8 store address", 32'(ext_addr), 32'h22);
  endtask

  task automatic t_alu_loadm;
    apply(8'hA6, 8'h00);
    chk("R9 compare writes nothing", 32'(dst_we), 32'h0);
    apply(8'hEF, 8'h00);
    chk("R9 load-mem dest and strobe", 32'({dst_we, dst_sel, mem_re}), 32'hD);
    chk("R9 load-mem address", 32'(ext_addr), 32'h44);
    apply(8'h68, 8'h00);
    chk("R9 load-mem K from memory", 32'(k_q), 32'hA5);
    chk("R13 load-mem is not a prefix", 32'(pfx_act), 32'h0);
  endtask

  task automatic t_zero;
    alu_res = 8'h00;
    apply(8'hA6, 8'h00);
    apply(8'h68, 8'h00);
    chk("R12 zero flag set", 32'(zero_flag), 32'h1);
    alu_res = 8'h77;
    apply(8'h68, 8'h00);
    chk("R12 zero flag clear", 32'(zero_flag), 32'h0);
  endtask

  task automatic t_refresh;
    while (exp_rfc != 8'hFF) apply(8'h68, 8'h00);
    chk("R10 counter at top", 32'(ext_addr), 32'hFF);
    apply(8'h68, 8'h00);
    chk("R10 counter wraps", 32'(ext_addr), 32'h00);
    apply(8'h6D, 8'h00);
    chk("R8 store address after wrap", 32'(ext_addr), 32'h22);
    apply(8'h68, 8'h00);
    chk("R10 store held counter", 32'(ext_addr), 32'h01);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_srcsel();
    t_const();
    t_branch();
    t_mem();
    t_inp();
    t_out_sta();
    t_alu_loadm();
    t_zero();
    t_refresh();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule